// File: doc/BRIEF.md
# Privilege Mode and Exception Controller

This block tracks the system mode of one execution engine and decides, for every raised exception, which mode comes next. There are three nested modes: user code runs unprivileged. The kernel runs in supervisor mode. A third, fault mode handles double faults and debug events that are raised while the kernel is running. The block takes single-cycle requests from the synchronous exception sources (supervisor call, data fault, periodic timer tick, debug). It also takes requests from the asynchronous sources (management console, I/O), a return-from-exception strobe and a flag that marks an attempt to use a privileged instruction or register.

For each cycle the block picks at most one exception by fixed priority. It then reports a one-cycle taken strobe with a 3-bit cause code and moves to the new mode. A return that is not masked by an exception restores the mode that was saved on entry. Asynchronous requests stay pending until they are served. Synchronous requests that lose arbitration are dropped. An exception in fault mode, or a return from a double fault, stops the engine through a sticky halt output that only reset clears. Saving the program counter, vector tables and the timer belong to other blocks.

Top module: `priv_exc_ctrl`

## Requirements
- R1: After reset the mode is supervisor, the privileged flag is 1, the taken strobe is 0, the cause is 0, the halt output is 0 and no exception is pending.
- R2: The mode output uses user = 0, supervisor = 1, fault = 2 and never shows 3. The privileged flag is 0 in user mode and 1 in the other two modes.
- R3: An exception raised in user mode switches to supervisor mode. The request is sampled at a clock edge; at that same edge the mode changes and the taken strobe rises for one cycle with the cause. The cause codes are supervisor call 1, data fault 2, privilege violation 3, debug 4, timer tick 5, management console 6 and I/O 7. While the strobe is 0 the cause reads 0.
- R4: A non-debug exception taken in supervisor mode is a double fault and switches to fault mode.
- R5: A debug exception taken in supervisor mode switches to fault mode. The next return from fault mode goes back to supervisor mode, and halt stays at 0.
- R6: A return in supervisor mode restores the mode saved at supervisor entry; this is user after reset. A return in fault mode after a double fault sets halt.
- R7: In user mode, an asserted privileged-operation flag or a return strobe raises a privilege violation (cause 3). In supervisor or fault mode the privileged-operation flag has no effect.
- R8: When several requests arrive in one cycle, the priority from highest to lowest is data fault, privilege violation, supervisor call, debug, timer tick, management console, I/O. A synchronous request that loses is discarded.
- R9: An asynchronous request that is not served stays pending and is taken later, with no need to reassert it.
- R10: An exception taken in fault mode sets halt and takes its strobe and cause. Once halt is 1, the mode stays fault and no further exception or return has any effect until reset.
- R11: When an exception and a return arrive in the same cycle, the exception is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| svc_req | input | 1 | Supervisor call request |
| dfault_req | input | 1 | Data fault request |
| tick_req | input | 1 | Periodic timer tick request |
| dbg_req | input | 1 | Debug exception request |
| console_req | input | 1 | Management console event (asynchronous) |
| io_req | input | 1 | I/O event (asynchronous) |
| eret_i | input | 1 | Return-from-exception strobe |
| priv_op_i | input | 1 | Attempt to use a privileged instruction or register |
| mode_o | output | 2 | Current mode: 0 user, 1 supervisor, 2 fault |
| privileged_o | output | 1 | High in supervisor and fault mode |
| exc_taken_o | output | 1 | One-cycle strobe when an exception is taken |
| cause_o | output | 3 | Cause code, valid with the strobe |
| halt_o | output | 1 | Sticky halt request |

## Verification
Each exception source is raised alone from user, supervisor and fault mode. This separates the three escalation paths and the debug detour that returns to supervisor. Several requests are raised in one cycle, both synchronous pairs and mixed synchronous/asynchronous pairs. These show the priority order, and they show that a losing asynchronous request is served on the next cycle while a losing synchronous one is lost. A return is applied in every mode, both alone and together with an exception. This tells a restore apart from a privilege violation, from a halt and from a masked return.

// File: rtl/priv_exc_pkg.sv
package priv_exc_pkg;

    localparam int MODE_W  = 2;
    localparam int CAUSE_W = 3;
    localparam int N_SRC   = 7;
    localparam int N_ASYNC = 2;
    localparam int IDX_W   = $clog2(N_SRC);
    // arbitration slot of the first asynchronous source
    localparam int ASYNC_BASE = N_SRC - N_ASYNC;
    localparam int DBG_SLOT   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_FAULT = 2'd2
    } mode_e;

    // arbitration slot (0 = highest priority) to reported cause
    function automatic logic [CAUSE_W-1:0] slot_cause(input logic [IDX_W-1:0] slot);
        case (slot)
            3'd0:    slot_cause = 3'd2; // data fault
            3'd1:    slot_cause = 3'd3; // privilege violation
            3'd2:    slot_cause = 3'd1; // supervisor call
            3'd3:    slot_cause = 3'd4; // debug
            3'd4:    slot_cause = 3'd5; // timer tick
            3'd5:    slot_cause = 3'd6; // console
            default: slot_cause = 3'd7; // I/O
        endcase
    endfunction

    typedef struct packed {
        mode_e               mode;
        mode_e               sup_save;
        mode_e               flt_save;
        logic                dbg_entry;
        logic                halt;
        logic                taken;
        logic [CAUSE_W-1:0]  cause;
    } ctrl_state_t;

endpackage

// File: rtl/pexc_async_hold.sv
module pexc_async_hold #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_o = pend_q | req_i;
        pend_d = pend_o & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/pexc_prio_pick.sv
module pexc_prio_pick #(
    parameter int N     = 7,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/priv_exc_ctrl.sv
module priv_exc_ctrl
    import priv_exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               svc_req,
    input  logic               dfault_req,
    input  logic               tick_req,
    input  logic               dbg_req,
    input  logic               console_req,
    input  logic               io_req,
    input  logic               eret_i,
    input  logic               priv_op_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic               privileged_o,
    output logic               exc_taken_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               halt_o
);
    ctrl_state_t         st_d, st_q;
    logic [N_ASYNC-1:0]  async_pend, async_clr;
    logic [N_SRC-1:0]    src_vec;
    logic                viol, pick_any;
    logic [IDX_W-1:0]    pick_idx;

    pexc_async_hold #(.N(N_ASYNC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  ({io_req, console_req}),
        .clr_i  (async_clr),
        .pend_o (async_pend)
    );

    assign viol    = (priv_op_i | eret_i) & (st_q.mode == MODE_USER);
    assign src_vec = {async_pend, tick_req, dbg_req, svc_req, viol, dfault_req};

    pexc_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
        .req_i (src_vec),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.cause = '0;
        async_clr  = '0;
        if (!st_q.halt) begin
            if (pick_any) begin
                st_d.taken = 1'b1;
                st_d.cause = slot_cause(pick_idx);
                for (int k = 0; k < N_ASYNC; k++) begin
                    async_clr[k] = (int'(pick_idx) == ASYNC_BASE + k);
                end
                case (st_q.mode)
                    MODE_USER: begin
                        st_d.mode     = MODE_SUPER;
                        st_d.sup_save = MODE_USER;
                    end
                    MODE_SUPER: begin
                        st_d.mode      = MODE_FAULT;
                        st_d.flt_save  = MODE_SUPER;
                        st_d.dbg_entry = (int'(pick_idx) == DBG_SLOT);
                    end
                    default: st_d.halt = 1'b1;
                endcase
            end else if (eret_i) begin
                case (st_q.mode)
                    MODE_SUPER: st_d.mode = st_q.sup_save;
                    MODE_FAULT: begin
                        if (st_q.dbg_entry) st_d.mode = st_q.flt_save;
                        else                st_d.halt = 1'b1;
                        st_d.dbg_entry = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SUPER, sup_save: MODE_USER, flt_save: MODE_SUPER,
                      dbg_entry: 1'b0, halt: 1'b0, taken: 1'b0, cause: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o       = st_q.mode;
    assign privileged_o = (st_q.mode != MODE_USER);
    assign exc_taken_o  = st_q.taken;
    assign cause_o      = st_q.cause;
    assign halt_o       = st_q.halt;
endmodule

// File: rtl/pexc_chk.sv
module pexc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       privileged_o,
    input logic       exc_taken_o,
    input logic [2:0] cause_o,
    input logic       halt_o
);
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    p_priv_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> !privileged_o);

    p_cause_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken_o |-> (cause_o == 3'd0));

    p_user_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken_o && $past(mode_o) == 2'd0) |-> (mode_o == 2'd1));

    p_double_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken_o && $past(mode_o) == 2'd1) |-> (mode_o == 2'd2));

    p_viol_from_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken_o && cause_o == 3'd3) |-> ($past(mode_o) == 2'd0));

    p_fault_exc_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken_o && $past(mode_o) == 2'd2) |-> halt_o);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (halt_o && mode_o == 2'd2 && !exc_taken_o));
endmodule

bind priv_exc_ctrl pexc_chk u_pexc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_o       (mode_o),
    .privileged_o (privileged_o),
    .exc_taken_o  (exc_taken_o),
    .cause_o      (cause_o),
    .halt_o       (halt_o)
);

// File: tb/tb_priv_exc_ctrl.sv
module tb_priv_exc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_req = 0, dfault_req = 0, tick_req = 0, dbg_req = 0;
    logic       console_req = 0, io_req = 0, eret_i = 0, priv_op_i = 0;
    logic [1:0] mode_o;
    logic       privileged_o, exc_taken_o, halt_o;
    logic [2:0] cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [1:0] U = 2'd0, S = 2'd1, F = 2'd2;

    always #4 clk = ~clk;

    priv_exc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .dfault_req(dfault_req),
        .tick_req(tick_req), .dbg_req(dbg_req), .console_req(console_req),
        .io_req(io_req), .eret_i(eret_i), .priv_op_i(priv_op_i),
        .mode_o(mode_o), .privileged_o(privileged_o), .exc_taken_o(exc_taken_o),
        .cause_o(cause_o), .halt_o(halt_o)
    );

    task automatic chk(input string req, input logic [1:0] m, input logic tk,
                       input logic [2:0] c, input logic h);
        logic p;
        p = (m != U);
        n_chk++;
        if (mode_o !== m || privileged_o !== p || exc_taken_o !== tk ||
            cause_o !== c || halt_o !== h) begin
            n_bad++;
            $display("FAIL %s: mode=%0d priv=%0b taken=%0b cause=%0d halt=%0b expected mode=%0d priv=%0b taken=%0b cause=%0d halt=%0b",
                     req, mode_o, privileged_o, exc_taken_o, cause_o, halt_o, m, p, tk, c, h);
        end
    endtask

    // apply the currently set inputs across one clock edge, then clear them
    task automatic cyc();
        @(posedge clk);
        #1;
        {svc_req, dfault_req, tick_req, dbg_req, console_req, io_req, eret_i, priv_op_i} = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", S, 0, 0, 0);
        cyc();
        chk("R1 idle after reset", S, 0, 0, 0);
    endtask

    task automatic t_user_entry();
        do_reset();
        eret_i = 1; cyc();
        chk("R6 return to user", U, 0, 0, 0);
        svc_req = 1; cyc();
        chk("R3 svc from user", S, 1, 3'd1, 0);
        cyc();
        chk("R3 strobe one cycle", S, 0, 0, 0);
        eret_i = 1; cyc();
        dfault_req = 1; cyc();
        chk("R3 data fault from user", S, 1, 3'd2, 0);
    endtask

    task automatic t_violation();
        do_reset();
        eret_i = 1; cyc();
        priv_op_i = 1; cyc();
        chk("R7 priv op in user", S, 1, 3'd3, 0);
        eret_i = 1; cyc();
        eret_i = 1; cyc();
        chk("R7 return in user", S, 1, 3'd3, 0);
        priv_op_i = 1; cyc();
        chk("R7 priv op in supervisor ignored", S, 0, 0, 0);
    endtask

    task automatic t_priority();
        do_reset();
        eret_i = 1; cyc();
        dfault_req = 1; svc_req = 1; tick_req = 1; cyc();
        chk("R8 data fault beats svc and tick", S, 1, 3'd2, 0);
        cyc();
        chk("R8 losing sync requests dropped", S, 0, 0, 0);
        eret_i = 1; cyc();
        priv_op_i = 1; svc_req = 1; cyc();
        chk("R8 violation beats svc", S, 1, 3'd3, 0);
        eret_i = 1; cyc();
        dbg_req = 1; tick_req = 1; cyc();
        chk("R8 debug beats tick", S, 1, 3'd4, 0);
    endtask

    task automatic t_async_hold();
        do_reset();
        eret_i = 1; cyc();
        svc_req = 1; io_req = 1; cyc();
        chk("R9 svc beats io", S, 1, 3'd1, 0);
        cyc();
        chk("R9 pending io taken, R4 double fault", F, 1, 3'd7, 0);
        cyc();
        chk("R9 io cleared after service", F, 0, 0, 0);
        eret_i = 1; cyc();
        chk("R6 return from double fault halts", F, 0, 0, 1);
    endtask

    task automatic t_console_io();
        do_reset();
        eret_i = 1; cyc();
        console_req = 1; io_req = 1; cyc();
        chk("R8 console beats io", S, 1, 3'd6, 0);
        cyc();
        chk("R9 io served next cycle", F, 1, 3'd7, 0);
    endtask

    task automatic t_debug_detour();
        do_reset();
        dbg_req = 1; cyc();
        chk("R5 debug in supervisor to fault", F, 1, 3'd4, 0);
        priv_op_i = 1; cyc();
        chk("R7 priv op in fault ignored", F, 0, 0, 0);
        eret_i = 1; cyc();
        chk("R5 debug return to supervisor", S, 0, 0, 0);
        tick_req = 1; cyc();
        chk("R4 tick in supervisor to fault", F, 1, 3'd5, 0);
    endtask

    task automatic t_fault_halt();
        do_reset();
        dbg_req = 1; cyc();
        tick_req = 1; cyc();
        chk("R10 exception in fault halts", F, 1, 3'd5, 1);
        eret_i = 1; cyc();
        chk("R10 return ignored when halted", F, 0, 0, 1);
        svc_req = 1; io_req = 1; cyc();
        chk("R10 requests ignored when halted", F, 0, 0, 1);
        do_reset();
        chk("R1 reset clears halt", S, 0, 0, 0);
    endtask

    task automatic t_eret_collision();
        do_reset();
        eret_i = 1; tick_req = 1; cyc();
        chk("R11 exception wins over return", F, 1, 3'd5, 0);
    endtask

    initial begin
        t_reset();
        t_user_entry();
        t_violation();
        t_priority();
        t_async_hold();
        t_console_io();
        t_debug_detour();
        t_fault_halt();
        t_eret_collision();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule